// File: doc/BRIEF.md
# Desaturation Fault Detector and Recovery Policy

This block sits between the PWM command for one power switch and the gate output stage. It watches a digital desaturation comparator and decides when a short circuit is genuine. Each turn-on starts a blanking interval that hides the comparator while the switch is still settling. After blanking, the comparator must stay high for a configurable number of consecutive cycles before a fault is declared. The comparator is also ignored whenever the switch is commanded off.

A confirmed fault removes the gate drive, asks the output stage for a soft turn-off for a fixed number of cycles, and pulls the active-low fault flag low. Recovery then follows one of two policies. In latch mode the block stays off until a clear command arrives while the supply is healthy. In retry mode it waits for a cooldown and then resumes, up to a configured number of times. Once those attempts are used up it latches. An undervoltage input acts as a hardware disable, and the gate stays off after it releases until the command has been seen low.

Top module: `desat_guard`

## Requirements
- R1: During and right after synchronous reset, `gate_o` and `soft_off_o` are 0 and `fault_n_o` is 1.
- R2: While the block is running and no undervoltage is present, `gate_o` equals `gate_cmd_i` delayed by one clock.
- R3: The comparator has no effect while `gate_cmd_i` is low, nor during the first `cfg_blank_i` clock edges of each on-period.
- R4: After blanking, a fault is declared only when the comparator is high on `cfg_filt_i` consecutive qualified edges (a value of 0 acts as 1). Any low sample restarts the count.
- R5: On the edge that declares a fault, `gate_o` goes 0, `soft_off_o` goes 1 for exactly `SOFT_CYC` cycles, and `fault_n_o` goes 0.
- R6: With `cfg_retry_en_i` = 0, after the soft turn-off the block stays latched: `gate_o` is 0 and `fault_n_o` is 0 until `clear_i` is sampled high with `uv_i` low. Normal operation then resumes.
- R7: With `cfg_retry_en_i` = 1 and attempts left, the soft turn-off is followed by a cooldown of `cfg_cool_i` cycles (0 acts as 1). During the cooldown the gate is off and `fault_n_o` is 0. After it, `fault_n_o` returns to 1 and the gate follows the command again.
- R8: Retry mode makes at most `cfg_retry_max_i` cooldown attempts. The next fault after that latches as in R6. A clear accepted while running or latched resets the attempt count to 0.
- R9: `uv_i` high forces `gate_o` to 0 on the next edge. After `uv_i` falls, `gate_o` stays 0 until `gate_cmd_i` has been sampled low once.
- R10: A clear sampled while `uv_i` is high does not release a latched fault.
- R11: `gate_o` and `soft_off_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_cmd_i | input | 1 | Turn-on command from PWM |
| cmp_i | input | 1 | Desaturation comparator output (synchronous) |
| uv_i | input | 1 | Undervoltage indication |
| clear_i | input | 1 | Fault clear command |
| cfg_blank_i | input | BLANK_W | Blanking length in cycles |
| cfg_filt_i | input | FILT_W | Required consecutive high samples |
| cfg_retry_en_i | input | 1 | 1 = bounded retry, 0 = latch |
| cfg_retry_max_i | input | RETRY_W | Maximum retry attempts |
| cfg_cool_i | input | COOL_W | Cooldown length in cycles |
| gate_o | output | 1 | Gate drive enable |
| soft_off_o | output | 1 | Soft turn-off request |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
All outputs are registered, so each one reflects the inputs sampled on the previous rising edge. The gate follows the command one edge later. A trip lands on edge `cfg_blank_i + cfg_filt_i - 1` counted from the turn-on edge, and the flag and soft request change on that same edge. The soft request drops `SOFT_CYC` edges later, and the flag returns `cfg_cool_i` edges after that. The bench drives inputs on falling edges. A behavioural model advances on every rising edge and is compared with all three outputs on the following falling edge, and the directed checks read the outputs only after the settling cycles listed here have passed.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_COOL  = 2'd2,
    ST_LATCH = 2'd3
  } rec_state_e;
endpackage

// File: rtl/dsg_blank_timer.sv
// Counts consecutive on-cycles; done once the count reaches the blanking length.
module dsg_blank_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !on_i) begin
      cnt <= '0;
    end else if (cnt < len_i) begin
      cnt <= cnt + W'(1);
    end
  end

  assign done_o = (cnt >= len_i);

  AST_BLANK_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!on_i && len_i != '0) |=> !done_o); // R3
endmodule

// File: rtl/dsg_persist_filter.sv
// Requires the comparator to stay high for len_i qualified samples in a row.
module dsg_persist_filter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on_i,
  input  logic         blank_done_i,
  input  logic         cmp_i,
  input  logic [W-1:0] len_i,
  output logic         trip_o
);
  localparam int CW = W + 1;

  logic [W-1:0]  cnt;
  logic [CW-1:0] need;
  logic          qual;

  assign qual   = on_i && blank_done_i && cmp_i;
  assign need   = (len_i == '0) ? CW'(1) : CW'(len_i);
  assign trip_o = qual && ((CW'(cnt) + CW'(1)) >= need);

  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      cnt <= '0;
    end else if (cnt != {W{1'b1}}) begin
      cnt <= cnt + W'(1);
    end
  end

  AST_FILT_HISTORY: assert property (@(posedge clk) disable iff (rst)
    (trip_o && len_i > W'(1)) |-> $past(cmp_i)); // R4
endmodule

// File: rtl/dsg_recovery.sv
// Fault policy: soft turn-off, then cooldown/retry or latch until clear.
module dsg_recovery
  import dsg_pkg::*;
#(
  parameter int RETRY_W  = 3,
  parameter int COOL_W   = 10,
  parameter int SOFT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trip_i,
  input  logic               retry_en_i,
  input  logic [RETRY_W-1:0] retry_max_i,
  input  logic [COOL_W-1:0]  cool_i,
  input  logic               clear_i,
  input  logic               uv_i,
  output rec_state_e         state_o,
  output rec_state_e         nxt_o
);
  localparam int SOFT_W = $clog2(SOFT_CYC + 1);
  localparam int TW     = (COOL_W > SOFT_W) ? COOL_W : SOFT_W;

  rec_state_e         st, nxt;
  logic [TW-1:0]      tmr;
  logic [RETRY_W-1:0] rcnt;
  logic [TW:0]        cool_need;
  logic               soft_done, cool_done, clr_ok, timed;

  assign cool_need = (cool_i == '0) ? (TW+1)'(1) : (TW+1)'(cool_i);
  assign soft_done = ((TW+1)'(tmr) + (TW+1)'(1)) >= (TW+1)'(SOFT_CYC);
  assign cool_done = ((TW+1)'(tmr) + (TW+1)'(1)) >= cool_need;
  assign clr_ok    = clear_i && !uv_i;
  assign timed     = (st == ST_SOFT) || (st == ST_COOL);

  always_comb begin
    nxt = st;
    case (st)
      ST_RUN:   if (trip_i) nxt = ST_SOFT;
      ST_SOFT:  if (soft_done) nxt = (retry_en_i && rcnt < retry_max_i) ? ST_COOL : ST_LATCH;
      ST_COOL:  if (cool_done) nxt = ST_RUN;
      ST_LATCH: if (clr_ok) nxt = ST_RUN;
      default:  nxt = ST_LATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RUN;
      tmr  <= '0;
      rcnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st || !timed) tmr <= '0;
      else                     tmr <= tmr + TW'(1);
      if (st == ST_SOFT && nxt == ST_COOL)
        rcnt <= rcnt + RETRY_W'(1);
      else if ((st == ST_RUN || st == ST_LATCH) && clr_ok)
        rcnt <= '0;
    end
  end

  assign state_o = st;
  assign nxt_o   = nxt;

  AST_TRIP_TO_SOFT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && trip_i) |=> st == ST_SOFT); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && (!clear_i || uv_i)) |=> st == ST_LATCH); // R10
  AST_COOL_COUNTED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COOL) |-> rcnt != '0); // R8
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import dsg_pkg::*;
#(
  parameter int BLANK_W  = 8,
  parameter int FILT_W   = 6,
  parameter int RETRY_W  = 3,
  parameter int COOL_W   = 10,
  parameter int SOFT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_cmd_i,
  input  logic               cmp_i,
  input  logic               uv_i,
  input  logic               clear_i,
  input  logic [BLANK_W-1:0] cfg_blank_i,
  input  logic [FILT_W-1:0]  cfg_filt_i,
  input  logic               cfg_retry_en_i,
  input  logic [RETRY_W-1:0] cfg_retry_max_i,
  input  logic [COOL_W-1:0]  cfg_cool_i,
  output logic               gate_o,
  output logic               soft_off_o,
  output logic               fault_n_o
);
  rec_state_e state, nxt;
  logic       uv_block_q, on_req, blank_done, trip;

  assign on_req = gate_cmd_i && !uv_i && !uv_block_q && (state == ST_RUN);

  dsg_blank_timer #(.W(BLANK_W)) u_blank (
    .clk    (clk),
    .rst    (rst),
    .on_i   (on_req),
    .len_i  (cfg_blank_i),
    .done_o (blank_done)
  );

  dsg_persist_filter #(.W(FILT_W)) u_filt (
    .clk          (clk),
    .rst          (rst),
    .on_i         (on_req),
    .blank_done_i (blank_done),
    .cmp_i        (cmp_i),
    .len_i        (cfg_filt_i),
    .trip_o       (trip)
  );

  dsg_recovery #(
    .RETRY_W  (RETRY_W),
    .COOL_W   (COOL_W),
    .SOFT_CYC (SOFT_CYC)
  ) u_rec (
    .clk         (clk),
    .rst         (rst),
    .trip_i      (trip),
    .retry_en_i  (cfg_retry_en_i),
    .retry_max_i (cfg_retry_max_i),
    .cool_i      (cfg_cool_i),
    .clear_i     (clear_i),
    .uv_i        (uv_i),
    .state_o     (state),
    .nxt_o       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o     <= 1'b0;
      soft_off_o <= 1'b0;
      fault_n_o  <= 1'b1;
      uv_block_q <= 1'b0;
    end else begin
      gate_o     <= on_req && !trip;
      soft_off_o <= (nxt == ST_SOFT);
      fault_n_o  <= (nxt == ST_RUN);
      uv_block_q <= uv_i || (uv_block_q && gate_cmd_i);
    end
  end

  AST_GATE_SOFT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate_o && soft_off_o)); // R11
  AST_UV_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    uv_i |=> !gate_o); // R9
  AST_FLAG_WITH_SOFT: assert property (@(posedge clk) disable iff (rst)
    soft_off_o |-> !fault_n_o); // R5
endmodule

// File: tb/tb_desat_guard.sv
`timescale 1ns/1ps
module tb_desat_guard;
  localparam int SOFT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gate_cmd = 0, cmp = 0, uv = 0, clear = 0;
  logic [7:0] cfg_blank = 8'd5;
  logic [5:0] cfg_filt = 6'd3;
  logic       cfg_retry_en = 0;
  logic [2:0] cfg_retry_max = 3'd2;
  logic [9:0] cfg_cool = 10'd6;
  logic       gate_o, soft_off_o, fault_n_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  desat_guard #(.SOFT_CYC(SOFT)) dut (
    .clk(clk), .rst(rst), .gate_cmd_i(gate_cmd), .cmp_i(cmp), .uv_i(uv),
    .clear_i(clear), .cfg_blank_i(cfg_blank), .cfg_filt_i(cfg_filt),
    .cfg_retry_en_i(cfg_retry_en), .cfg_retry_max_i(cfg_retry_max),
    .cfg_cool_i(cfg_cool), .gate_o(gate_o), .soft_off_o(soft_off_o),
    .fault_n_o(fault_n_o)
  );

  // Behavioural reference: 0 run, 1 soft, 2 cooldown, 3 latched
  int m_st, m_age, m_hits, m_t, m_r, nx, need, coolv;
  bit m_uvb, on, hi, trip, clr, e_gate, e_soft, e_fn;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_age = 0; m_hits = 0; m_t = 0; m_r = 0; m_uvb = 0;
      e_gate = 0; e_soft = 0; e_fn = 1;
    end else begin
      on    = gate_cmd && !uv && !m_uvb && (m_st == 0);
      hi    = on && (m_age >= int'(cfg_blank)) && cmp;
      need  = (cfg_filt == 0) ? 1 : int'(cfg_filt);
      coolv = (cfg_cool == 0) ? 1 : int'(cfg_cool);
      trip  = hi && (m_hits + 1 >= need);
      clr   = clear && !uv;
      nx = m_st;
      case (m_st)
        0: if (trip) nx = 1;
        1: if (m_t + 1 >= SOFT) nx = (cfg_retry_en && m_r < int'(cfg_retry_max)) ? 2 : 3;
        2: if (m_t + 1 >= coolv) nx = 0;
        default: if (clr) nx = 3 - 3;
      endcase
      if (m_st == 1 && nx == 2) m_r++;
      else if ((m_st == 0 || m_st == 3) && clr) m_r = 0;
      m_t    = (nx != m_st || m_st == 0 || m_st == 3) ? 0 : m_t + 1;
      e_gate = on && !trip;
      e_soft = (nx == 1);
      e_fn   = (nx == 0);
      m_age  = on ? m_age + 1 : 0;
      m_hits = hi ? m_hits + 1 : 0;
      m_uvb  = uv || (m_uvb && gate_cmd);
      m_st   = nx;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(gate_o, e_gate, "R2", "gate_o vs model");
      chk(soft_off_o, e_soft, "R5", "soft_off_o vs model");
      chk(fault_n_o, e_fn, "R6", "fault_n_o vs model");
      chk(gate_o && soft_off_o, 1'b0, "R11", "gate/soft overlap");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fault();
    for (int i = 0; i < 100; i++) begin
      if (fault_n_o == 1'b0) break;
      tick(1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    chk(gate_o, 0, "R1", "gate in reset");
    chk(soft_off_o, 0, "R1", "soft in reset");
    chk(fault_n_o, 1, "R1", "flag in reset");
    rst = 0;
    tick(1);
    chk(fault_n_o, 1, "R1", "flag after reset");

    // R2: gate follows the command, comparator quiet
    gate_cmd = 1; tick(1);
    chk(gate_o, 1, "R2", "gate one edge after command");
    tick(20);
    chk(gate_o, 1, "R2", "gate held on");
    gate_cmd = 0; tick(1);
    chk(gate_o, 0, "R2", "gate one edge after release");

    // R3: comparator ignored while off and during blanking
    cmp = 1; tick(10);
    chk(fault_n_o, 1, "R3", "comparator while off");
    gate_cmd = 1; tick(4); cmp = 0; tick(5);
    chk(fault_n_o, 1, "R3", "comparator inside blanking");
    chk(gate_o, 1, "R3", "gate still on after blanked pulse");

    // R4: short spikes rejected
    cmp = 1; tick(2); cmp = 0; tick(1); cmp = 1; tick(2); cmp = 0; tick(3);
    chk(fault_n_o, 1, "R4", "two-sample spikes rejected");

    // R5: sustained high trips
    cmp = 1; tick(3); cmp = 0;
    chk(soft_off_o, 1, "R5", "soft request on trip");
    chk(gate_o, 0, "R5", "gate off on trip");
    chk(fault_n_o, 0, "R5", "flag low on trip");
    tick(4);
    chk(soft_off_o, 0, "R5", "soft request ends");
    tick(10);
    chk(fault_n_o, 0, "R6", "latched flag");
    chk(gate_o, 0, "R6", "latched gate off");

    // R10 / R6: clear under undervoltage, then valid clear
    uv = 1; clear = 1; tick(1); clear = 0; tick(2);
    chk(fault_n_o, 0, "R10", "clear under undervoltage ignored");
    uv = 0; gate_cmd = 0; tick(1);
    clear = 1; tick(1); clear = 0;
    chk(fault_n_o, 1, "R6", "released by clear");
    gate_cmd = 1; tick(2);
    chk(gate_o, 1, "R6", "running after clear");

    // R7 / R8: bounded retry
    cfg_retry_en = 1;
    for (int k = 0; k < 2; k++) begin
      cmp = 1; wait_fault(); cmp = 0;
      tick(6);
      chk(gate_o, 0, "R7", "gate off in cooldown");
      chk(fault_n_o, 0, "R7", "flag low in cooldown");
      tick(6);
      chk(fault_n_o, 1, "R7", "recovered after cooldown");
      tick(2);
      chk(gate_o, 1, "R7", "gate follows command after retry");
    end
    cmp = 1; wait_fault(); cmp = 0;
    tick(20);
    chk(fault_n_o, 0, "R8", "latched after retries used");
    clear = 1; tick(1); clear = 0; tick(2);
    chk(fault_n_o, 1, "R8", "clear after exhaustion");
    cmp = 1; wait_fault(); cmp = 0;
    tick(12);
    chk(fault_n_o, 1, "R8", "count reset by clear allows retry");

    // R9: undervoltage disable and rearm
    tick(3);
    chk(gate_o, 1, "R9", "running before undervoltage");
    uv = 1; tick(1);
    chk(gate_o, 0, "R9", "undervoltage forces off");
    uv = 0; tick(3);
    chk(gate_o, 0, "R9", "no re-enable with command held");
    gate_cmd = 0; tick(1); gate_cmd = 1; tick(1);
    chk(gate_o, 1, "R9", "re-enable after command low");

    // R4: zero filter and zero blanking trip on first sample
    cfg_filt = 0; cfg_blank = 0; tick(2);
    cmp = 1; tick(1); cmp = 0;
    chk(soft_off_o, 1, "R4", "filter of zero trips at once");
    tick(15);
    chk(fault_n_o, 1, "R7", "recovered after zero-filter trip");

    tick(5);
    finish_run();
  end
endmodule